// File: doc/BRIEF.md
# Clock-Synthesizer Configuration Slave (Two-Wire Serial)

This block is the register side of a clock synthesizer's serial configuration port. It watches a two-wire serial bus as SCL and SDA samples that are already synchronized to the system clock. It drives the data line only through an open-drain pull-down enable. When a transfer is addressed to it, the block acknowledges each byte and keeps a small bank of seven byte-wide registers. The spread-spectrum and output-driver controls are decoded from those registers and appear directly on output pins.

A command byte follows the address. When the top bit of the command is set, the access is a single byte at the offset given by the low seven bits. When the top bit is clear, the access is a block transfer. A block transfer always starts at register zero and carries a length byte. On a write, the master sends the length byte. On a read, the slave sends it. Reads use a repeated START and then the read address. The master ends a read by not acknowledging the last byte, followed by STOP.

Top module: `sscfg_slave`

## Requirements
- R1: After reset, register 0 holds 0x0A and register 1 holds 0xCC. The decoded outputs therefore reset to spread_sel=0, spread_en=1, pd_tristate=0, ref_en=1, ref_slew=1, clk_slew=1 and clk_en=1.
- R2: The slave acknowledges an address byte only if its upper seven bits equal 0x6A (0xD4 for write, 0xD5 for read). For any other address it never pulls SDA low, and it ignores the bus until the next START.
- R3: Byte write: address 0xD4, then a command with bit 7 = 1 and offset in bits [6:0], then one data byte. Every byte is acknowledged and the data lands at that offset.
- R4: Byte read: 0xD4, then a command with bit 7 = 1 and offset, then repeated START, then 0xD5. The slave returns the register at that offset, MSB first. Bit 3 of register 0 always reads 1, whatever was written.
- R5: Block write: 0xD4, then command 0x00, then a length byte, then data. Every byte is acknowledged. Data goes to offsets 0, 1, 2 and upward in order, and the master may STOP after any whole byte.
- R6: Block read: 0xD4, then 0x00, then repeated START, then 0xD5. The slave returns the length byte 7 and then registers 0 upward. It stops driving once the master NACKs, and the master may NACK early.
- R7: Register 6 is read-only and reads 0x08. Writes to it are acknowledged and discarded.
- R8: Offsets 7 and above are acknowledged, read as 0x00 and discard writes. This includes block-write data past offset 6.
- R9: A START or STOP that arrives partway through a byte abandons the transfer and leaves every register unchanged. A new START is then decoded normally.
- R10: Outputs follow the registers. spread_sel=reg0[7:4], pd_tristate=reg0[2], spread_en=reg0[1], ref_en=reg1[7], ref_slew=reg1[6], clk_slew=reg1[3], clk_en=reg1[2]. They change only in the cycle after a register write.
- R11: The SDA pull-down changes only just after a falling SCL edge, and it is released after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample (wired bus level) |
| sda_oe | output | 1 | 1 pulls SDA low |
| spread_sel | output | 4 | Spread amount/mode select code |
| spread_en | output | 1 | Spread modulation enable |
| pd_tristate | output | 1 | Power-down output behaviour: 0 three-state, 1 drive low |
| ref_en | output | 1 | Reference output enable |
| ref_slew | output | 1 | Reference edge rate: 0 slow, 1 nominal |
| clk_slew | output | 1 | Main clock edge rate: 0 slow, 1 nominal |
| clk_en | output | 1 | Main clock output enable |

## Verification
Address decoding is tried with all 256 address bytes. This separates a correct 7-bit match from a compare that ignores the direction bit or a single address bit, and it confirms that the read address starts returning data. Single-byte writes are swept over offsets 0 to 8, and the whole map is read back after each one. This exposes a wrong offset decode, a writable ID register, the forced bit in register 0 and the zero reads above the map. Block writes are swept over lengths 1 to 9 with changing data and then read back as a full block and as a short block. These show whether the length byte is skipped, whether the pointer order is right and whether data past the map is ignored. Transfers cut off by a START or a STOP partway through a byte show whether a partial byte can reach a register.

// File: rtl/sscfg_pkg.sv
`timescale 1ns/100ps
package sscfg_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_CMD,
    ST_ACK_CMD,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_ACK_TX,
    ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/sscfg_rst_sync.sv
`timescale 1ns/100ps
module sscfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) pipe_q <= '0;
    else          pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = pipe_q[STAGES-1];
endmodule

// File: rtl/sscfg_bus_events.sv
`timescale 1ns/100ps
module sscfg_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moving while SCL stays high marks a bus condition
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & ~sda_i & sda_q;
  assign stop_det  = scl_i & scl_q & sda_i & ~sda_q;
endmodule

// File: rtl/sscfg_regbank.sv
`timescale 1ns/100ps
module sscfg_regbank #(
  parameter int          NUM_REGS = 7,
  parameter int          ADDR_W   = 7,
  parameter logic [7:0]  DEF0     = 8'h0A,
  parameter logic [7:0]  DEF1     = 8'hCC,
  parameter logic [7:0]  FORCE0   = 8'h08,
  parameter logic [7:0]  ID_VAL   = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [3:0]        spread_sel,
  output logic              spread_en,
  output logic              pd_tristate,
  output logic              ref_en,
  output logic              ref_slew,
  output logic              clk_slew,
  output logic              clk_en
);
  // last register is the read-only identifier, the rest are writable
  localparam int RW_REGS = NUM_REGS - 1;
  localparam int IDX_W   = $clog2(NUM_REGS);

  logic [7:0] rw_q [RW_REGS];

  for (genvar g = 0; g < RW_REGS; g++) begin : g_rw
    localparam logic [7:0] RST_V = (g == 0) ? DEF0 : ((g == 1) ? DEF1 : 8'h00);
    localparam logic [7:0] ONES  = (g == 0) ? FORCE0 : 8'h00;
    logic [7:0] q;
    logic       hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_V;
      else if (hit) q <= wr_data | ONES;
    end

    assign rw_q[g] = q;
  end

  always_comb begin
    if (rd_addr < ADDR_W'(RW_REGS))       rd_data = rw_q[rd_addr[IDX_W-1:0]];
    else if (rd_addr == ADDR_W'(RW_REGS)) rd_data = ID_VAL;
    else                                  rd_data = 8'h00;
  end

  assign spread_sel  = rw_q[0][7:4];
  assign pd_tristate = rw_q[0][2];
  assign spread_en   = rw_q[0][1];
  assign ref_en      = rw_q[1][7];
  assign ref_slew    = rw_q[1][6];
  assign clk_slew    = rw_q[1][3];
  assign clk_en      = rw_q[1][2];
endmodule

// File: rtl/sscfg_slave.sv
`timescale 1ns/100ps
module sscfg_slave
  import sscfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         NUM_REGS = 7,
  parameter logic [7:0] DEF0     = 8'h0A,
  parameter logic [7:0] DEF1     = 8'hCC,
  parameter logic [7:0] ID_VAL   = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [3:0] spread_sel,
  output logic       spread_en,
  output logic       pd_tristate,
  output logic       ref_en,
  output logic       ref_slew,
  output logic       clk_slew,
  output logic       clk_en
);
  localparam int                ADDR_W    = 7;
  localparam logic [7:0]        BLK_COUNT = 8'(NUM_REGS);
  localparam logic [ADDR_W-1:0] PTR_MAX   = '1;
  localparam logic [3:0]        LAST_BIT  = 4'(BYTE_W);

  logic rst_ns;
  logic scl_rise, scl_fall, start_det, stop_det;

  slv_state_e         st_q, st_d;
  logic [3:0]         cnt_q, cnt_d;
  logic [7:0]         sh_q, sh_d;
  logic [7:0]         tx_q, tx_d;
  logic [ADDR_W-1:0]  ptr_q, ptr_d, ptr_inc;
  logic               pend_q, pend_d;   // length byte still due
  logic               rd_q, rd_d;
  logic               nack_q, nack_d;
  logic               wr_en;
  logic [7:0]         rd_data;

  sscfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_ns)
  );

  sscfg_bus_events u_evt (
    .clk(clk), .rst_n(rst_ns), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sscfg_regbank #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DEF0(DEF0), .DEF1(DEF1),
    .FORCE0(8'h08), .ID_VAL(ID_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_ns),
    .wr_en(wr_en), .wr_addr(ptr_q), .wr_data(sh_q),
    .rd_addr(ptr_q), .rd_data(rd_data),
    .spread_sel(spread_sel), .spread_en(spread_en), .pd_tristate(pd_tristate),
    .ref_en(ref_en), .ref_slew(ref_slew), .clk_slew(clk_slew), .clk_en(clk_en)
  );

  // pointer saturates so a long block never wraps back onto register 0
  assign ptr_inc = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    pend_d = pend_q;
    rd_d   = rd_q;
    nack_d = nack_q;
    wr_en  = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
    end else if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_ADDR, ST_CMD, ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_i};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            cnt_d = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                rd_d = sh_q[0];
                st_d = ST_ACK_ADDR;
              end else begin
                st_d = ST_WAIT;
              end
            end else if (st_q == ST_CMD) begin
              pend_d = ~sh_q[7];
              ptr_d  = sh_q[7] ? sh_q[6:0] : '0;
              st_d   = ST_ACK_CMD;
            end else begin
              if (pend_q) begin
                pend_d = 1'b0;
              end else begin
                wr_en = 1'b1;
                ptr_d = ptr_inc;
              end
              st_d = ST_ACK_RX;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            if (rd_q) begin
              if (pend_q) begin
                tx_d   = BLK_COUNT;
                pend_d = 1'b0;
              end else begin
                tx_d  = rd_data;
                ptr_d = ptr_inc;
              end
              st_d = ST_TX;
            end else begin
              st_d = ST_CMD;
            end
          end
        end
        ST_ACK_CMD, ST_ACK_RX: begin
          if (scl_fall) st_d = ST_RX;
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              cnt_d = '0;
              st_d  = ST_ACK_TX;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
            end
          end
        end
        ST_ACK_TX: begin
          if (scl_rise) begin
            nack_d = sda_i;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_d = ST_WAIT;
            end else begin
              tx_d  = rd_data;
              ptr_d = ptr_inc;
              st_d  = ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      pend_q <= 1'b0;
      rd_q   <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
      rd_q   <= rd_d;
      nack_q <= nack_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_ACK_ADDR, ST_ACK_CMD, ST_ACK_RX: sda_oe = 1'b1;
      ST_TX:                              sda_oe = ~tx_q[7];
      default:                            sda_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/sscfg_slave_chk.sv
`timescale 1ns/100ps
module sscfg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [9:0] cfg_bus
);
  logic scl_p, sda_p;
  logic stop_seen, scl_fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end

  assign stop_seen = scl_i & scl_p & sda_i & ~sda_p;
  assign scl_fell  = scl_p & ~scl_i;

  // R11: pull-down toggles only right after SCL has fallen
  p_oe_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fell));

  // R11: bus released once a STOP is seen
  p_release_on_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);

  // R5: every stored data byte is acknowledged
  p_ack_after_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R10: decoded controls move only after a register write
  p_cfg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bus) |-> $past(wr_en));
endmodule

bind sscfg_slave sscfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .wr_en(wr_en),
  .cfg_bus({spread_sel, spread_en, pd_tristate, ref_en, ref_slew, clk_slew, clk_en})
);

// File: tb/sscfg_slave_test.sv
`timescale 1ns/100ps
module sscfg_slave_test;
  localparam int HALF   = 4;
  localparam int MAXCYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [3:0] spread_sel;
  logic spread_en, pd_tristate, ref_en, ref_slew, clk_slew, clk_en;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [7:0] mdl [7];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  sscfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .spread_sel(spread_sel), .spread_en(spread_en), .pd_tristate(pd_tristate),
    .ref_en(ref_en), .ref_slew(ref_slew), .clk_slew(clk_slew), .clk_en(clk_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int off);
    return (off < 7) ? mdl[off] : 8'h00;
  endfunction

  function automatic void mdl_wr(input int off, input logic [7:0] v);
    if (off == 0)     mdl[0] = v | 8'h08;
    else if (off < 6) mdl[off] = v;
  endfunction

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic bstop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; half(); scl_m = 1'b1; half(); scl_m = 1'b0; half();
    end
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    ack = ~sda_bus;
    scl_m = 1'b0; half();
  endtask

  task automatic wb_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    wb(b, a);
    chk(req, {7'd0, a}, {7'd0, exp_ack});
  endtask

  task automatic rb(input logic nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl_m = 1'b1; half(); d[i] = sda_bus; scl_m = 1'b0;
    end
    half(); sda_m = nack; half(); scl_m = 1'b1; half(); scl_m = 1'b0; half();
    sda_m = 1'b1;
  endtask

  task automatic byte_write(input int off, input logic [7:0] v);
    bstart();
    wb_chk(8'hD4, 1'b1, "R3");
    wb_chk({1'b1, 7'(off)}, 1'b1, "R3");
    wb_chk(v, 1'b1, (off > 6) ? "R8" : ((off == 6) ? "R7" : "R3"));
    bstop();
    mdl_wr(off, v);
  endtask

  task automatic byte_read(input int off, output logic [7:0] d);
    bstart();
    wb_chk(8'hD4, 1'b1, "R4");
    wb_chk({1'b1, 7'(off)}, 1'b1, "R4");
    bstart();
    wb_chk(8'hD5, 1'b1, "R4");
    rb(1'b1, d);
    bstop();
  endtask

  task automatic block_read(input int n);
    logic [7:0] d;
    bstart();
    wb_chk(8'hD4, 1'b1, "R6");
    wb_chk(8'h00, 1'b1, "R6");
    bstart();
    wb_chk(8'hD5, 1'b1, "R6");
    rb(1'b0, d);
    chk("R6 count", d, 8'd7);
    for (int i = 0; i < n; i++) begin
      rb(i == n - 1, d);
      chk((i == 6) ? "R7 block" : "R6 data", d, exp_rd(i));
    end
    bstop();
  endtask

  task automatic chk_outs(input string req);
    chk(req, {4'd0, spread_sel}, {4'd0, mdl[0][7:4]});
    chk(req, {2'd0, pd_tristate, spread_en, ref_en, ref_slew, clk_slew, clk_en},
        {2'd0, mdl[0][2], mdl[0][1], mdl[1][7], mdl[1][6], mdl[1][3], mdl[1][2]});
  endtask

  initial begin
    logic [7:0] d;
    logic a;
    mdl[0] = 8'h0A; mdl[1] = 8'hCC; mdl[2] = 8'h00; mdl[3] = 8'h00;
    mdl[4] = 8'h00; mdl[5] = 8'h00; mdl[6] = 8'h08;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset values on pins and in the map
    chk_outs("R1");
    chk("R1 sda", {7'd0, sda_oe}, 8'd0);
    for (int off = 0; off < 9; off++) begin
      byte_read(off, d);
      chk("R1 read", d, exp_rd(off));
    end

    // R2: every address byte, only 0xD4/0xD5 acknowledged
    for (int ab = 0; ab < 256; ab++) begin
      bstart();
      wb(8'(ab), a);
      chk("R2", {7'd0, a}, {7'd0, (ab[7:1] == 7'h6A)});
      if (ab == 8'hD5) rb(1'b1, d);
      bstop();
    end

    // R3 R4 R7 R8 R10: single-byte writes over the map and beyond
    for (int off = 0; off < 9; off++) begin
      byte_write(off, 8'(off * 53 + 17) ^ 8'hA4);
      chk_outs("R10");
      for (int r = 0; r < 9; r++) begin
        byte_read(r, d);
        chk((r == 0) ? "R4 forced bit" : ((r > 6) ? "R8" : "R4"), d, exp_rd(r));
      end
    end

    // R5 R8: block writes of length 1..9, then full block read
    for (int n = 1; n < 10; n++) begin
      bstart();
      wb_chk(8'hD4, 1'b1, "R5");
      wb_chk(8'h00, 1'b1, "R5");
      wb_chk(8'(n), 1'b1, "R5");
      for (int i = 0; i < n; i++) begin
        logic [7:0] v;
        v = 8'(n * 29 + i * 71) ^ 8'h3C;
        wb_chk(v, 1'b1, (i > 6) ? "R8" : "R5");
        mdl_wr(i, v);
      end
      bstop();
      chk_outs("R10 block");
      block_read(7);
    end

    // R6: short block read with an early NACK
    block_read(2);
    block_read(1);

    // R2: writes to a foreign address leave everything unchanged
    bstart();
    wb_chk(8'hD6, 1'b0, "R2");
    wb_chk(8'h80, 1'b0, "R2");
    wb_chk(8'hFF, 1'b0, "R2");
    bstop();
    block_read(7);

    // R9: STOP partway through a data byte
    bstart();
    wb_chk(8'hD4, 1'b1, "R9");
    wb_chk(8'h82, 1'b1, "R9");
    send_bits(8'h5B, 4);
    bstop();
    byte_read(2, d);
    chk("R9 stop", d, exp_rd(2));

    // R9: START partway through a data byte, then a clean transfer
    bstart();
    wb_chk(8'hD4, 1'b1, "R9");
    wb_chk(8'h80, 1'b1, "R9");
    send_bits(8'h00, 5);
    bstart();
    wb_chk(8'hD4, 1'b1, "R9");
    wb_chk(8'h83, 1'b1, "R9");
    wb_chk(8'h3C, 1'b1, "R9");
    bstop();
    mdl_wr(3, 8'h3C);
    byte_read(0, d);
    chk("R9 start", d, exp_rd(0));
    byte_read(3, d);
    chk("R9 restart", d, 8'h3C);
    chk("R11 idle", {7'd0, sda_oe}, 8'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (MAXCYC) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule